// File: doc/BRIEF.md
# VGA Attribute Register Port

This block is the host-facing register file of a display attribute controller. Software reaches it through a byte-wide I/O bus that carries an address, a read strobe, a write strobe, write data and registered read data. The block keeps 21 byte-wide attribute registers. A register write takes two accesses to one shared address. The first access selects a register and the second carries the value. A single toggle bit inside the block tracks which of the two comes next.

Each register applies its own write mask, so bits that do not exist read back as zero. A program that has lost track of the toggle can resynchronise. It reads the input-status port, and that read always returns the toggle to the "index next" state. The status port has one of two addresses, and a mode input picks which one is live. Palette lookup and pixel processing that use these registers lie outside this block.

Top module: `vga_attr_port`

## Requirements
- R1: A synchronous reset (active high) clears the toggle bit to 0 (index next), the 6-bit index to 0, all 21 registers to 0 and the read data output to 0.
- R2: A write to address 0x3C0 while the toggle bit is 0 stores bits 5:0 of the write data as the index. Bits 7:6 are dropped.
- R3: Every write to 0x3C0 inverts the toggle bit, whether the write was an index write or a data write. No other access changes the bit, except the status read in R8.
- R4: A write to 0x3C0 while the toggle bit is 1 goes to the register numbered by index bits 4:0, through that register's mask. Registers 0x00 to 0x0F keep data bits 5:0. Register 0x10 keeps every bit except bit 4. Register 0x11 keeps all 8 bits. Register 0x12 keeps bits 5:0. Registers 0x13 and 0x14 keep bits 3:0. Masked-off bits read as 0.
- R5: A data write whose index bits 4:0 are 21 or more changes no register. It still inverts the toggle bit.
- R6: A read of 0x3C0 returns the index, zero-extended to 8 bits, when the toggle bit is 0, and returns 0x00 when it is 1.
- R7: A read of 0x3C1 returns the register numbered by index bits 4:0 when that number is below 21, and returns 0x00 otherwise. Index bit 5 plays no part in selecting a register.
- R8: A read of the input-status port clears the toggle bit to 0 and returns 0x00. The status port is 0x3DA when the mode input is 0 (colour) and 0x3BA when it is 1 (mono). The address of the other mode has no effect on the toggle bit.
- R9: Read data appears on the output one clock after the cycle in which the read strobe is sampled high. It holds its value in every cycle without a read.
- R10: Writes to any address other than 0x3C0 change nothing. Reads of any address not named in R6 to R8 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mono_sel | input | 1 | 0 selects the colour status address, 1 selects the mono address |
| addr | input | ADDR_W (16) | I/O address of the access |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid one clock after rd_en |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 21 registers and the standard index, data and status addresses. With 21 registers and a 5-bit selector, every out-of-range selector from 21 to 31 can be reached. Setting index bit 5 also shows that this bit never moves the selection. Both mode settings are driven, so the bench covers the live status address clearing the toggle bit while the address of the other mode leaves it alone.

// File: rtl/vga_attr_pkg.sv
package vga_attr_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 6;
    localparam int SEL_W  = 5;

    typedef logic [DATA_W-1:0] byte_t;

    // decoded access kinds for one bus cycle
    typedef struct packed {
        logic idx_wr;     // write to the shared index/data address
        logic idx_rd;     // read of the shared index/data address
        logic data_rd;    // read of the data readback address
        logic status_rd;  // read of the live input-status address
    } acc_dec_t;

    // per-register write masks
    function automatic byte_t attr_mask(input logic [SEL_W-1:0] sel);
        byte_t m;
        if (sel < 5'h10)       m = 8'h3F;
        else if (sel == 5'h10) m = 8'hEF;
        else if (sel == 5'h11) m = 8'hFF;
        else if (sel == 5'h12) m = 8'h3F;
        else                   m = 8'h0F;
        return m;
    endfunction

endpackage

// File: rtl/vga_attr_decode.sv
module vga_attr_decode
    import vga_attr_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] PORT_INDEX  = 'h3C0,
    parameter logic [ADDR_W-1:0] PORT_DATA   = 'h3C1,
    parameter logic [ADDR_W-1:0] PORT_STAT_C = 'h3DA,
    parameter logic [ADDR_W-1:0] PORT_STAT_M = 'h3BA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              mono_sel,
    output acc_dec_t          dec
);

    logic [ADDR_W-1:0] stat_addr;

    always_comb begin
        stat_addr     = mono_sel ? PORT_STAT_M : PORT_STAT_C;
        dec           = '0;
        dec.idx_wr    = wr_en && (addr == PORT_INDEX);
        dec.idx_rd    = rd_en && (addr == PORT_INDEX);
        dec.data_rd   = rd_en && (addr == PORT_DATA);
        dec.status_rd = rd_en && (addr == stat_addr);
    end

endmodule

// File: rtl/vga_attr_regfile.sv
module vga_attr_regfile
    import vga_attr_pkg::*;
#(
    parameter int unsigned NUM_REGS = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  byte_t            wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output byte_t            rd_data
);

    localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W+1)'(NUM_REGS);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;
    logic                            wr_hit, rd_hit;

    always_comb begin
        wr_hit = wr_en && ({1'b0, wr_sel} < SEL_LIMIT);
        rd_hit = {1'b0, rd_sel} < SEL_LIMIT;
        regs_d = regs_q;
        for (int i = 0; i < int'(NUM_REGS); i++) begin
            if (wr_hit && (wr_sel == SEL_W'(i)))
                regs_d[i] = wr_data & attr_mask(SEL_W'(i));
        end
        rd_data = rd_hit ? regs_q[rd_sel] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    // R5
    out_of_range_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !({1'b0, wr_sel} < SEL_LIMIT)) |=> $stable(regs_q));

    genvar g;
    generate
        for (g = 0; g < int'(NUM_REGS); g++) begin : g_mask_chk
            // R4
            masked_bits_chk: assert property (@(posedge clk) disable iff (rst)
                (regs_q[g] & ~attr_mask(SEL_W'(g))) == '0);
        end
    endgenerate

endmodule

// File: rtl/vga_attr_port.sv
module vga_attr_port
    import vga_attr_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 16,
    parameter int unsigned       NUM_REGS    = 21,
    parameter logic [ADDR_W-1:0] PORT_INDEX  = 'h3C0,
    parameter logic [ADDR_W-1:0] PORT_DATA   = 'h3C1,
    parameter logic [ADDR_W-1:0] PORT_STAT_C = 'h3DA,
    parameter logic [ADDR_W-1:0] PORT_STAT_M = 'h3BA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mono_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    typedef struct packed {
        logic             data_next;  // toggle: 1 = next write is data
        logic [IDX_W-1:0] idx;
        byte_t            rdata;
    } seq_t;

    seq_t     seq_d, seq_q;
    acc_dec_t dec;
    byte_t    rf_rd_data;
    logic     rf_wr;

    vga_attr_decode #(
        .ADDR_W     (ADDR_W),
        .PORT_INDEX (PORT_INDEX),
        .PORT_DATA  (PORT_DATA),
        .PORT_STAT_C(PORT_STAT_C),
        .PORT_STAT_M(PORT_STAT_M)
    ) decode_i (
        .addr    (addr),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .mono_sel(mono_sel),
        .dec     (dec)
    );

    assign rf_wr = dec.idx_wr && seq_q.data_next;

    vga_attr_regfile #(
        .NUM_REGS(NUM_REGS)
    ) regfile_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (rf_wr),
        .wr_sel (seq_q.idx[SEL_W-1:0]),
        .wr_data(wdata),
        .rd_sel (seq_q.idx[SEL_W-1:0]),
        .rd_data(rf_rd_data)
    );

    always_comb begin
        seq_d = seq_q;
        if (dec.idx_wr) begin
            if (!seq_q.data_next) seq_d.idx = wdata[IDX_W-1:0];
            seq_d.data_next = !seq_q.data_next;
        end
        if (dec.status_rd) seq_d.data_next = 1'b0;
        if (rd_en) begin
            if (dec.idx_rd)
                seq_d.rdata = seq_q.data_next ? '0 : byte_t'(seq_q.idx);
            else if (dec.data_rd)
                seq_d.rdata = rf_rd_data;
            else
                seq_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign rdata = seq_q.rdata;

    // R3
    flip_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        dec.idx_wr |=> (seq_q.data_next != $past(seq_q.data_next)));

    // R3
    toggle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!dec.idx_wr && !dec.status_rd) |=> $stable(seq_q.data_next));

    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        dec.status_rd |=> !seq_q.data_next);

    // R6
    index_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.idx_rd && seq_q.data_next) |=> (rdata == '0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/vga_attr_port_tb.sv
module vga_attr_port_tb_top;

    localparam logic [15:0] A_IDX = 16'h03C0;
    localparam logic [15:0] A_DAT = 16'h03C1;
    localparam logic [15:0] A_STC = 16'h03DA;
    localparam logic [15:0] A_STM = 16'h03BA;

    logic        clk = 1'b0;
    logic        rst;
    logic        mono_sel;
    logic [15:0] addr;
    logic        rd_en, wr_en;
    logic [7:0]  wdata;
    logic [7:0]  rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    vga_attr_port dut_i (
        .clk(clk), .rst(rst), .mono_sel(mono_sel), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] exp_mask(input int r);
        if (r <= 15)            return 8'h3F;
        if (r == 16)            return 8'hEF;
        if (r == 17)            return 8'hFF;
        if (r == 18)            return 8'h3F;
        if (r == 19 || r == 20) return 8'h0F;
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic resync();
        logic [7:0] junk;
        bus_rd(mono_sel ? A_STM : A_STC, junk);
    endtask

    task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
        resync();
        bus_wr(A_IDX, i);
        bus_wr(A_IDX, v);
    endtask

    task automatic get_reg(input logic [7:0] i, output logic [7:0] v);
        resync();
        bus_wr(A_IDX, i);
        bus_rd(A_DAT, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 rdata after reset", rdata, 8'h00);
        bus_rd(A_IDX, v);
        chk("R1 index after reset", v, 8'h00);
        for (int i = 0; i < 21; i++) begin
            get_reg(8'(i), v);
            chk("R1 register after reset", v, 8'h00);
        end
    endtask

    task automatic t_index();
        logic [7:0] v;
        resync();
        bus_wr(A_IDX, 8'hFF);
        bus_rd(A_IDX, v);
        chk("R6 index read while data next", v, 8'h00);
        resync();
        bus_rd(A_IDX, v);
        chk("R2 index keeps bits 5:0", v, 8'h3F);
    endtask

    task automatic t_toggle();
        logic [7:0] v;
        resync();
        bus_wr(A_IDX, 8'h05);
        bus_wr(A_IDX, 8'hAA);
        bus_wr(A_IDX, 8'h07);
        bus_rd(A_IDX, v);
        chk("R3 third write was an index write", v, 8'h00);
        bus_wr(A_IDX, 8'h11);
        bus_rd(A_IDX, v);
        chk("R3 fourth write toggled back", v, 8'h07);
        get_reg(8'h05, v);
        chk("R4 reg 5 masked data", v, 8'h2A);
        get_reg(8'h07, v);
        chk("R4 reg 7 data", v, 8'h11);
    endtask

    task automatic t_masks();
        logic [7:0] v;
        for (int i = 0; i < 21; i++) begin
            set_reg(8'(i), 8'hFF);
            get_reg(8'(i), v);
            chk("R4 mask all ones", v, exp_mask(i));
            set_reg(8'(i), 8'hA5);
            get_reg(8'(i), v);
            chk("R4 mask pattern", v, 8'hA5 & exp_mask(i));
        end
    endtask

    task automatic t_range();
        logic [7:0] v;
        for (int i = 0; i < 21; i++) set_reg(8'(i), 8'h00);
        for (int i = 21; i < 32; i++) set_reg(8'(i), 8'hFF);
        set_reg(8'h35, 8'hFF);
        for (int i = 0; i < 21; i++) begin
            get_reg(8'(i), v);
            chk("R5 out-of-range write discarded", v, 8'h00);
        end
        set_reg(8'h11, 8'h77);
        get_reg(8'h11, v);
        chk("R7 in-range readback", v, 8'h77);
        get_reg(8'h15, v);
        chk("R7 selector 21 reads zero", v, 8'h00);
        get_reg(8'h1F, v);
        chk("R7 selector 31 reads zero", v, 8'h00);
        set_reg(8'h25, 8'h13);
        get_reg(8'h05, v);
        chk("R7 index bit 5 ignored", v, 8'h13);
        resync();
        bus_wr(A_IDX, 8'h15);
        bus_wr(A_IDX, 8'hFF);
        bus_rd(A_IDX, v);
        chk("R5 discarded write still toggles", v, 8'h15);
    endtask

    task automatic t_status();
        logic [7:0] v;
        mono_sel = 1'b0;
        resync();
        bus_wr(A_IDX, 8'h0A);
        bus_rd(A_STM, v);
        chk("R8 mono address inert in colour mode", v, 8'h00);
        bus_rd(A_IDX, v);
        chk("R8 toggle kept in colour mode", v, 8'h00);
        bus_rd(A_STC, v);
        chk("R8 status read returns zero", v, 8'h00);
        bus_rd(A_IDX, v);
        chk("R8 colour status clears toggle", v, 8'h0A);
        mono_sel = 1'b1;
        bus_wr(A_IDX, 8'h0B);
        bus_rd(A_STC, v);
        bus_rd(A_IDX, v);
        chk("R8 colour address inert in mono mode", v, 8'h00);
        bus_rd(A_STM, v);
        bus_rd(A_IDX, v);
        chk("R8 mono status clears toggle", v, 8'h0B);
        mono_sel = 1'b0;
    endtask

    task automatic t_timing();
        logic [7:0] v;
        set_reg(8'h11, 8'hC3);
        resync();
        bus_wr(A_IDX, 8'h11);
        bus_rd(A_DAT, v);
        chk("R9 value one clock after strobe", v, 8'hC3);
        repeat (3) @(negedge clk);
        chk("R9 held while idle", rdata, 8'hC3);
        addr = A_DAT; rd_en = 1'b1;
        chk("R9 old value before edge", rdata, 8'hC3);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9 new read repeats value", rdata, 8'hC3);
    endtask

    task automatic t_other();
        logic [7:0] v;
        set_reg(8'h03, 8'h21);
        resync();
        bus_wr(A_IDX, 8'h03);
        bus_wr(A_DAT, 8'h3F);
        bus_wr(16'h0123, 8'h3F);
        bus_rd(16'h0123, v);
        chk("R10 unknown address reads zero", v, 8'h00);
        bus_rd(A_IDX, v);
        chk("R10 toggle untouched by other writes", v, 8'h00);
        bus_rd(A_DAT, v);
        chk("R10 register untouched by other writes", v, 8'h21);
    endtask

    initial begin
        rst = 1'b1; mono_sel = 1'b0; addr = '0;
        rd_en = 1'b0; wr_en = 1'b0; wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_index();
        t_toggle();
        t_masks();
        t_range();
        t_status();
        t_timing();
        t_other();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("watchdog expired before the run completed");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule